// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This controller sits between the core's sleep logic and the clock tree. A one-cycle sleep request latches a decoded low-power mode. The controller then drives one enable for each clock domain: the main oscillator, the CPU, general I/O, a dedicated timer on either an asynchronous or a synchronous clock, the ADC and the analog comparator. A wake event starts a mode-dependent start-up interval. The awake flag returns only when that interval has fully elapsed.

On top of the sleep modes, a per-peripheral power-reduction vector can stop the clock of any single peripheral. While its bit is set, that peripheral is also fenced off from the register bus. Reads from it return zero, writes to it are dropped, and a one-cycle error pulse reports each such attempt. When the bit is cleared, the clock comes back and nothing in the peripheral has changed.

All pins are plain control or status levels. There is no streaming interface, so no back-pressure rules apply.

Top module: `slp_clk_ctrl`

## Requirements
- R1: Mode decode on a sleep request while awake uses these `slp_code_i` values: 000 Idle, 001 ADC-quiet, 010 Power-down, 011 Power-save, 110 Standby when `xtal_sel_i`=1 and Power-down otherwise, and any other code Idle. `awake_o` drops on the cycle after the request. A sleep request while not awake is ignored, and so is a wake event while awake.
- R2: While awake, the oscillator, CPU and I/O enables are all 1.
- R3: In Idle, the CPU enable is 0 and the I/O and oscillator enables are 1. In ADC-quiet, the CPU and I/O enables are 0 and the oscillator enable is 1.
- R4: In Power-down, the oscillator, CPU, I/O, both timer and comparator enables are 0. Standby behaves the same, except that the oscillator enable stays 1.
- R5: In Power-save, the asynchronous timer enable follows `tmr_async_sel_i` and the synchronous timer enable follows `tmr_sync_sel_i`. The oscillator enable equals `tmr_sync_sel_i`. The CPU and I/O enables are 0.
- R6: `awake_o` rises a set number of clock edges after the edge that samples `wake_i`: 1 edge for Idle and ADC-quiet, 6 edges for Standby, and WAKE_CYCLES edges for Power-down and Power-save. The oscillator enable is 1 throughout the wake interval.
- R7: `per_clk_en_o[i]` is 1 only when the I/O domain runs (awake or Idle) and `pwr_red_i[i]`=0. `per_acc_block_o` equals `pwr_red_i`.
- R8: When the selected peripheral is gated, `acc_rdata_o` is zero and a write raises no `per_wr_en_o` bit. When it is not gated, the read data passes through unchanged and a write raises the one-hot `per_wr_en_o[acc_sel_i]`.
- R9: `acc_err_o` is 1 for exactly the cycle after any cycle that has a read or write to a gated peripheral, and is 0 after an access to an ungated one.
- R10: `adc_clk_en_o` equals `adc_en_i` in every state. `adc_ext_conv_o` is 1 after reset and after each rising edge of `adc_en_i`. A conversion start while the ADC is enabled clears it.
- R11: `cmp_clk_en_o` is 1 only when `cmp_en_i`=1 and the controller is awake, in Idle, or in ADC-quiet. `vref_en_o` equals `cmp_en_i & cmp_intref_i` in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slp_code_i | input | 3 | Requested sleep mode code |
| sleep_req_i | input | 1 | One-cycle sleep request |
| wake_i | input | 1 | Wake event |
| xtal_sel_i | input | 1 | External crystal clock option selected |
| tmr_async_sel_i | input | 1 | Dedicated timer uses the asynchronous clock |
| tmr_sync_sel_i | input | 1 | Dedicated timer uses the synchronous clock |
| adc_en_i | input | 1 | ADC enabled |
| adc_conv_start_i | input | 1 | ADC conversion start |
| cmp_en_i | input | 1 | Comparator enabled |
| cmp_intref_i | input | 1 | Comparator uses the internal reference |
| pwr_red_i | input | N_PER | Per-peripheral clock stop bits |
| acc_sel_i | input | SEL_W | Peripheral addressed on the register bus |
| acc_rd_i | input | 1 | Register read attempt |
| acc_wr_i | input | 1 | Register write attempt |
| per_rdata_i | input | DATA_W | Read data from the addressed peripheral |
| acc_rdata_o | output | DATA_W | Read data returned to the bus |
| per_wr_en_o | output | N_PER | Forwarded write strobe, one-hot |
| acc_err_o | output | 1 | Gated-access error pulse |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| io_clk_en_o | output | 1 | I/O clock enable |
| tmr_async_clk_en_o | output | 1 | Timer asynchronous clock enable |
| tmr_sync_clk_en_o | output | 1 | Timer synchronous clock enable |
| adc_clk_en_o | output | 1 | ADC clock enable |
| adc_ext_conv_o | output | 1 | Next conversion is an extended one |
| cmp_clk_en_o | output | 1 | Comparator clock enable |
| vref_en_o | output | 1 | Internal reference enable |
| per_clk_en_o | output | N_PER | Per-peripheral clock enable |
| per_acc_block_o | output | N_PER | Per-peripheral register access blocked |
| awake_o | output | 1 | CPU running |

## Verification
The assertions assume two things about the register bus. First, `acc_sel_i` always addresses an existing peripheral. Second, reads and writes are not issued while the stop bit of the addressed peripheral is changing. The stimulus changes `pwr_red_i` only on cycles with no access in progress. The assertions also assume that `wake_i` and `sleep_req_i` are driven from the same clock. The bench drives every input at the falling edge, so each request is seen at exactly one rising edge.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    MD_IDLE,
    MD_ADCQ,
    MD_PDOWN,
    MD_PSAVE,
    MD_STBY
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WAKE
  } slp_state_e;
endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [2:0] code_i,
  input  logic       xtal_i,
  output slp_mode_e  mode_o
);
  always_comb begin
    unique case (code_i)
      3'b001:  mode_o = MD_ADCQ;
      3'b010:  mode_o = MD_PDOWN;
      3'b011:  mode_o = MD_PSAVE;
      3'b110:  mode_o = xtal_i ? MD_STBY : MD_PDOWN;
      default: mode_o = MD_IDLE;
    endcase
  end
endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
  import slp_pkg::*;
#(
  parameter int WAKE_CYCLES = 32,
  parameter int STBY_CYCLES = 6
) (
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  input  slp_mode_e  mode_i,
  output slp_state_e state_o,
  output slp_mode_e  mode_o,
  output logic       awake_o
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);

  slp_state_e    state_q;
  slp_mode_e     mode_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] delay;

  // Start-up length depends on how much of the clock tree was stopped
  always_comb begin
    unique case (mode_q)
      MD_IDLE, MD_ADCQ: delay = CW'(1);
      MD_STBY:          delay = CW'(STBY_CYCLES);
      default:          delay = CW'(WAKE_CYCLES);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= MD_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (sleep_req_i) begin
          state_q <= ST_SLEEP;
          mode_q  <= mode_i;
        end
        ST_SLEEP: if (wake_i) begin
          state_q <= ST_WAKE;
          cnt_q   <= delay - CW'(1);
        end
        ST_WAKE: begin
          if (cnt_q == '0) state_q <= ST_RUN;
          else             cnt_q   <= cnt_q - CW'(1);
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign awake_o = (state_q == ST_RUN);

  AST_SLEEP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_SLEEP && !wake_i) |=> (state_q == ST_SLEEP && $stable(mode_q))); // R1
  AST_WAKE_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(awake_o) |-> ($past(state_q) == ST_WAKE)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == ST_WAKE) |-> (cnt_q < CW'(WAKE_CYCLES))); // R6
endmodule

// File: rtl/slp_domain_gate.sv
module slp_domain_gate
  import slp_pkg::*;
#(
  parameter int N_PER = 4
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  slp_state_e       state_i,
  input  slp_mode_e        mode_i,
  input  logic             tmr_async_sel_i,
  input  logic             tmr_sync_sel_i,
  input  logic             adc_en_i,
  input  logic             cmp_en_i,
  input  logic             cmp_intref_i,
  input  logic [N_PER-1:0] pwr_red_i,
  output logic             osc_en_o,
  output logic             cpu_en_o,
  output logic             io_en_o,
  output logic             async_en_o,
  output logic             sync_en_o,
  output logic             adc_en_o,
  output logic             cmp_en_o,
  output logic             vref_en_o,
  output logic [N_PER-1:0] per_en_o
);
  logic run, waking;

  assign run    = (state_i == ST_RUN);
  assign waking = (state_i == ST_WAKE);

  always_comb begin
    osc_en_o   = 1'b1;
    cpu_en_o   = run;
    io_en_o    = run;
    async_en_o = tmr_async_sel_i;
    sync_en_o  = tmr_sync_sel_i;
    cmp_en_o   = cmp_en_i;
    if (!run) begin
      unique case (mode_i)
        MD_IDLE: io_en_o = 1'b1;
        MD_ADCQ: ;
        MD_PSAVE: begin
          osc_en_o = tmr_sync_sel_i | waking;
          cmp_en_o = 1'b0;
        end
        MD_STBY: begin
          async_en_o = 1'b0;
          sync_en_o  = 1'b0;
          cmp_en_o   = 1'b0;
        end
        default: begin
          osc_en_o   = waking;
          async_en_o = 1'b0;
          sync_en_o  = 1'b0;
          cmp_en_o   = 1'b0;
        end
      endcase
    end
  end

  assign adc_en_o  = adc_en_i;
  assign vref_en_o = cmp_en_i & cmp_intref_i;
  assign per_en_o  = io_en_o ? ~pwr_red_i : '0;

  AST_STBY_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i == ST_SLEEP && mode_i == MD_STBY) |-> osc_en_o); // R4
  AST_PSAVE_CORE_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i != ST_RUN && mode_i == MD_PSAVE) |-> (!io_en_o && !cpu_en_o)); // R5
  AST_DEEP_PER_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!io_en_o) |-> (per_en_o == '0)); // R7
  AST_WAKE_OSC_ON: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_i == ST_WAKE) |-> osc_en_o); // R6
endmodule

// File: rtl/slp_access_guard.sv
module slp_access_guard #(
  parameter int N_PER  = 4,
  parameter int DATA_W = 8,
  parameter int SEL_W  = (N_PER > 1) ? $clog2(N_PER) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [N_PER-1:0]  pwr_red_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PER-1:0]  wr_en_o,
  output logic              err_o
);
  logic gated;
  logic err_q;

  assign gated   = pwr_red_i[sel_i];
  assign rdata_o = gated ? '0 : rdata_i;

  always_comb begin
    wr_en_o = '0;
    if (wr_i && !gated) wr_en_o[sel_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (rd_i | wr_i) & gated;
  end

  assign err_o = err_q;

  AST_GATED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_i && pwr_red_i[sel_i]) |-> (wr_en_o == '0)); // R8
  AST_ERR_FOLLOWS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> $past(rd_i | wr_i)); // R9
  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(wr_en_o)); // R8
endmodule

// File: rtl/slp_clk_ctrl.sv
module slp_clk_ctrl
  import slp_pkg::*;
#(
  parameter int N_PER       = 4,
  parameter int DATA_W      = 8,
  parameter int WAKE_CYCLES = 32,
  parameter int SEL_W       = (N_PER > 1) ? $clog2(N_PER) : 1
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [2:0]        slp_code_i,
  input  logic              sleep_req_i,
  input  logic              wake_i,
  input  logic              xtal_sel_i,
  input  logic              tmr_async_sel_i,
  input  logic              tmr_sync_sel_i,
  input  logic              adc_en_i,
  input  logic              adc_conv_start_i,
  input  logic              cmp_en_i,
  input  logic              cmp_intref_i,
  input  logic [N_PER-1:0]  pwr_red_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic              acc_rd_i,
  input  logic              acc_wr_i,
  input  logic [DATA_W-1:0] per_rdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic [N_PER-1:0]  per_wr_en_o,
  output logic              acc_err_o,
  output logic              osc_en_o,
  output logic              cpu_clk_en_o,
  output logic              io_clk_en_o,
  output logic              tmr_async_clk_en_o,
  output logic              tmr_sync_clk_en_o,
  output logic              adc_clk_en_o,
  output logic              adc_ext_conv_o,
  output logic              cmp_clk_en_o,
  output logic              vref_en_o,
  output logic [N_PER-1:0]  per_clk_en_o,
  output logic [N_PER-1:0]  per_acc_block_o,
  output logic              awake_o
);
  localparam int STBY_CYCLES = 6;

  slp_mode_e  req_mode, cur_mode;
  slp_state_e state;
  logic       adc_en_q, ext_q;

  slp_mode_decode u_dec (
    .code_i (slp_code_i),
    .xtal_i (xtal_sel_i),
    .mode_o (req_mode)
  );

  slp_wake_seq #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .STBY_CYCLES (STBY_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .mode_i      (req_mode),
    .state_o     (state),
    .mode_o      (cur_mode),
    .awake_o     (awake_o)
  );

  slp_domain_gate #(.N_PER(N_PER)) u_gate (
    .clk_i           (clk_i),
    .rst_n           (rst_n),
    .state_i         (state),
    .mode_i          (cur_mode),
    .tmr_async_sel_i (tmr_async_sel_i),
    .tmr_sync_sel_i  (tmr_sync_sel_i),
    .adc_en_i        (adc_en_i),
    .cmp_en_i        (cmp_en_i),
    .cmp_intref_i    (cmp_intref_i),
    .pwr_red_i       (pwr_red_i),
    .osc_en_o        (osc_en_o),
    .cpu_en_o        (cpu_clk_en_o),
    .io_en_o         (io_clk_en_o),
    .async_en_o      (tmr_async_clk_en_o),
    .sync_en_o       (tmr_sync_clk_en_o),
    .adc_en_o        (adc_clk_en_o),
    .cmp_en_o        (cmp_clk_en_o),
    .vref_en_o       (vref_en_o),
    .per_en_o        (per_clk_en_o)
  );

  slp_access_guard #(
    .N_PER  (N_PER),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_guard (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .pwr_red_i (pwr_red_i),
    .sel_i     (acc_sel_i),
    .rd_i      (acc_rd_i),
    .wr_i      (acc_wr_i),
    .rdata_i   (per_rdata_i),
    .rdata_o   (acc_rdata_o),
    .wr_en_o   (per_wr_en_o),
    .err_o     (acc_err_o)
  );

  assign per_acc_block_o = pwr_red_i;

  // Extended-conversion marker: armed at reset and on each ADC re-enable
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      adc_en_q <= 1'b0;
      ext_q    <= 1'b1;
    end else begin
      adc_en_q <= adc_en_i;
      if (adc_en_i && !adc_en_q)            ext_q <= 1'b1;
      else if (adc_conv_start_i && adc_en_i) ext_q <= 1'b0;
    end
  end

  assign adc_ext_conv_o = ext_q;

  AST_CPU_ONLY_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_n)
    cpu_clk_en_o |-> awake_o); // R2
  AST_EXT_ON_REENABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (adc_en_i && !adc_en_q) |=> adc_ext_conv_o); // R10
  AST_CMP_ASLEEP_DEEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmp_clk_en_o && !awake_o) |-> (cur_mode == MD_IDLE || cur_mode == MD_ADCQ)); // R11
endmodule

// File: tb/slp_clk_ctrl_tb_top.sv
module slp_clk_ctrl_tb_top;
  localparam int N     = 4;
  localparam int W     = 8;
  localparam int WAKE  = 32;
  localparam int SW    = 2;

  localparam int F_OSC = 0, F_CPU = 1, F_IO = 2, F_ASYNC = 3, F_SYNC = 4, F_ADC = 5,
                 F_CMP = 6, F_VREF = 7, F_AWAKE = 8, F_EXT = 9, F_PCLK = 10,
                 F_BLOCK = 11, F_WREN = 12, F_ERR = 13, F_RDATA = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] slp_code = 3'b000;
  logic sleep_req = 0, wake = 0, xtal = 0, t_async = 0, t_sync = 0;
  logic adc_en = 1, conv_start = 0, cmp_en = 1, cmp_ref = 1;
  logic [N-1:0] prr = 4'b0101;
  logic [SW-1:0] sel = '0;
  logic rd = 0, wr = 0;
  logic [W-1:0] pdata = 8'hAA;
  logic [W-1:0] rdata;
  logic [N-1:0] wr_en, pclk, block;
  logic err, osc, cpu, io, aclk, sclk, adcclk, ext, cmpclk, vref, awake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    int          f;
    logic [31:0] v;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  slp_clk_ctrl #(.N_PER(N), .DATA_W(W), .WAKE_CYCLES(WAKE)) dut_i (
    .clk_i(clk), .rst_n(rst_n), .slp_code_i(slp_code), .sleep_req_i(sleep_req),
    .wake_i(wake), .xtal_sel_i(xtal), .tmr_async_sel_i(t_async), .tmr_sync_sel_i(t_sync),
    .adc_en_i(adc_en), .adc_conv_start_i(conv_start), .cmp_en_i(cmp_en),
    .cmp_intref_i(cmp_ref), .pwr_red_i(prr), .acc_sel_i(sel), .acc_rd_i(rd),
    .acc_wr_i(wr), .per_rdata_i(pdata), .acc_rdata_o(rdata), .per_wr_en_o(wr_en),
    .acc_err_o(err), .osc_en_o(osc), .cpu_clk_en_o(cpu), .io_clk_en_o(io),
    .tmr_async_clk_en_o(aclk), .tmr_sync_clk_en_o(sclk), .adc_clk_en_o(adcclk),
    .adc_ext_conv_o(ext), .cmp_clk_en_o(cmpclk), .vref_en_o(vref),
    .per_clk_en_o(pclk), .per_acc_block_o(block), .awake_o(awake)
  );

  function automatic logic [31:0] observe(int f);
    case (f)
      F_OSC:   return 32'(osc);
      F_CPU:   return 32'(cpu);
      F_IO:    return 32'(io);
      F_ASYNC: return 32'(aclk);
      F_SYNC:  return 32'(sclk);
      F_ADC:   return 32'(adcclk);
      F_CMP:   return 32'(cmpclk);
      F_VREF:  return 32'(vref);
      F_AWAKE: return 32'(awake);
      F_EXT:   return 32'(ext);
      F_PCLK:  return 32'(pclk);
      F_BLOCK: return 32'(block);
      F_WREN:  return 32'(wr_en);
      F_ERR:   return 32'(err);
      default: return 32'(rdata);
    endcase
  endfunction

  // Driver side: queue an expected value for the current cycle
  task automatic ex(string tag, int f, logic [31:0] v);
    q.push_back('{tag, f, v});
  endtask

  // Monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] a;
        e = q.pop_front();
        a = observe(e.f);
        checks++;
        if (a !== e.v) begin
          errors++;
          $display("FAIL %s field %0d: actual %0h expected %0h", e.tag, e.f, a, e.v);
        end
      end
    end
  end

  task automatic go_sleep(logic [2:0] code);
    @(negedge clk);
    slp_code  = code;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic wake_up(int d, string tag);
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    ex(tag, F_OSC, 1);
    ex(tag, F_AWAKE, 0);
    for (int i = 1; i < d; i++) @(negedge clk);
    ex(tag, F_AWAKE, 0);
    @(negedge clk);
    ex(tag, F_AWAKE, 1);
    ex(tag, F_CPU, 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    ex("R2 reset", F_AWAKE, 1);
    ex("R2 reset", F_CPU, 1);
    ex("R2 reset", F_OSC, 1);
    ex("R2 reset", F_IO, 1);
    ex("R10 reset", F_EXT, 1);
    ex("R9 reset", F_ERR, 0);
    ex("R7 awake", F_PCLK, 4'b1010);
    ex("R7 block", F_BLOCK, 4'b0101);

    // Idle
    go_sleep(3'b000);
    ex("R1 idle", F_AWAKE, 0);
    ex("R3 idle", F_CPU, 0);
    ex("R3 idle", F_IO, 1);
    ex("R3 idle", F_OSC, 1);
    ex("R11 idle", F_CMP, 1);
    ex("R7 idle", F_PCLK, 4'b1010);
    wake_up(1, "R6 idle");

    // ADC-quiet
    go_sleep(3'b001);
    ex("R3 adcq", F_IO, 0);
    ex("R3 adcq", F_OSC, 1);
    ex("R11 adcq", F_CMP, 1);
    ex("R7 adcq", F_PCLK, 4'b0000);
    wake_up(1, "R6 adcq");

    // Power-down with both timer sources selected
    t_async = 1'b1;
    t_sync  = 1'b1;
    go_sleep(3'b010);
    ex("R4 pdown", F_OSC, 0);
    ex("R4 pdown", F_ASYNC, 0);
    ex("R4 pdown", F_SYNC, 0);
    ex("R11 pdown", F_CMP, 0);
    ex("R11 pdown", F_VREF, 1);
    ex("R10 pdown", F_ADC, 1);
    // Sleep request while asleep is ignored
    @(negedge clk);
    slp_code  = 3'b000;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    ex("R1 ignore sleep", F_OSC, 0);
    ex("R1 ignore sleep", F_IO, 0);
    ex("R1 ignore sleep", F_AWAKE, 0);
    wake_up(WAKE, "R6 pdown");

    // Standby with crystal
    xtal = 1'b1;
    go_sleep(3'b110);
    ex("R4 stby", F_OSC, 1);
    ex("R4 stby", F_IO, 0);
    ex("R4 stby", F_CPU, 0);
    ex("R4 stby", F_SYNC, 0);
    wake_up(6, "R6 stby");

    // Code 110 without crystal falls back to Power-down
    xtal = 1'b0;
    go_sleep(3'b110);
    ex("R1 110 no xtal", F_OSC, 0);
    wake_up(WAKE, "R6 pdown fallback");

    // Power-save on the asynchronous clock
    t_async = 1'b1;
    t_sync  = 1'b0;
    go_sleep(3'b011);
    ex("R5 psave async", F_ASYNC, 1);
    ex("R5 psave async", F_SYNC, 0);
    ex("R5 psave async", F_OSC, 0);
    ex("R5 psave async", F_IO, 0);
    wake_up(WAKE, "R6 psave");

    // Power-save on the synchronous clock
    t_async = 1'b0;
    t_sync  = 1'b1;
    go_sleep(3'b011);
    ex("R5 psave sync", F_SYNC, 1);
    ex("R5 psave sync", F_OSC, 1);
    ex("R5 psave sync", F_IO, 0);
    ex("R5 psave sync", F_ASYNC, 0);
    wake_up(WAKE, "R6 psave sync");

    // Unused code decodes to Idle
    go_sleep(3'b111);
    ex("R1 code 111", F_IO, 1);
    ex("R1 code 111", F_CPU, 0);
    wake_up(1, "R6 code 111");

    // Wake while awake is ignored
    @(negedge clk);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    ex("R1 ignore wake", F_AWAKE, 1);
    ex("R1 ignore wake", F_CPU, 1);

    // Gated read
    @(negedge clk);
    sel = 2'd0;
    rd  = 1'b1;
    ex("R8 gated read", F_RDATA, 0);
    ex("R9 gated read", F_ERR, 0);
    @(negedge clk);
    rd = 1'b0;
    ex("R9 err pulse", F_ERR, 1);
    @(negedge clk);
    ex("R9 err one cycle", F_ERR, 0);

    // Ungated read
    sel = 2'd1;
    rd  = 1'b1;
    ex("R8 open read", F_RDATA, 8'hAA);
    @(negedge clk);
    rd = 1'b0;
    ex("R9 no err", F_ERR, 0);

    // Gated write
    @(negedge clk);
    sel = 2'd2;
    wr  = 1'b1;
    ex("R8 gated write", F_WREN, 0);
    @(negedge clk);
    wr = 1'b0;
    ex("R9 write err", F_ERR, 1);

    // Ungated write
    @(negedge clk);
    sel = 2'd3;
    wr  = 1'b1;
    ex("R8 open write", F_WREN, 4'b1000);
    @(negedge clk);
    wr = 1'b0;
    ex("R9 open write", F_ERR, 0);

    // Clearing stop bits restores clocks
    @(negedge clk);
    prr = 4'b0000;
    ex("R7 cleared", F_PCLK, 4'b1111);
    ex("R7 cleared", F_BLOCK, 4'b0000);

    // ADC extended-conversion marker
    @(negedge clk);
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    ex("R10 cleared", F_EXT, 0);
    @(negedge clk);
    adc_en = 1'b0;
    ex("R10 adc off", F_ADC, 0);
    @(negedge clk);
    adc_en = 1'b1;
    @(negedge clk);
    ex("R10 reenable", F_EXT, 1);

    // Comparator with internal reference off
    cmp_ref = 1'b0;
    ex("R11 no ref", F_VREF, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule